// File: doc/BRIEF.md
# Dual-Bank ECC Error Logger

This block records ECC error details for two bus interfaces, a primary and a secondary. Each interface has its own bank of logging registers. A bank holds a nonzero error-phase code, the first and second error addresses, an attribute word, and two sticky flags. The first error seen on an armed bank (phase code zero) fills all of these fields. Every later error, correctable or uncorrectable, only sets the matching sticky flag. The primary interface never reports ECC errors, so its bank is permanently empty.

Software reaches both banks through one four-word register window. A select bit in the control/status word chooses which bank the window shows. On a write to the control/status word, the select bit in the written data chooses which bank's control/status fields are updated, and it also becomes the new select value.

Every piece of logging state, the select bit included, is cleared only by the power-good reset. The link reset clears only the read-data register.

Top module: `ecc_dual_log`

## Requirements
- R1: While `pg_rst_n` is low, all logging state, the select bit and `reg_rdata` are zero. After release, every offset reads zero in both banks.
- R2: A secondary error event with a nonzero phase code, arriving while the secondary phase field is zero, captures the phase code, `addr_lo` into the first-address word, `addr_hi` into the second-address word, `attr` into the attribute word, and the event type into the first-error-type bit. An event with phase code zero is ignored.
- R3: A secondary error that arrives while the phase field is nonzero leaves the phase, addresses, attribute and first-error type unchanged. It sets the additional-uncorrectable flag if `err_uncorr` is 1 and the additional-correctable flag otherwise.
- R4: Both additional-error flags are write-1-to-clear and stay set through writes of 0. When an error sets a flag in the same cycle that a write clears it, the flag ends up set.
- R5: Writing a nonzero value to the phase field of the control/status word clears the phase to zero and re-arms capture. The address and attribute words keep their values until the next capture.
- R6: The offsets are 0 for control/status, 1 for first address, 2 for second address and 3 for attribute. With the select bit (control/status bit 0) at 1 the window shows the secondary bank, and at 0 it shows the primary bank.
- R7: A write to offset 0 loads the select bit from written bit 0 and applies the clear bits only to the bank that the written bit 0 names. Writes to offsets 1 to 3 have no effect.
- R8: Control/status bit 1 (read-only) is 1 exactly when the bank that is not selected holds a nonzero phase code.
- R9: The primary bank never captures. All of its fields read zero whatever the primary error inputs do.
- R10: A low `link_rst_n` forces `reg_rdata` to zero and leaves all logging state and the select bit unchanged.
- R11: A read returns data on `reg_rdata` one clock after `reg_rd`. `reg_rdata` holds its value in cycles without a read.

Control/status layout: bit 0 select, bit 1 other-bank present, bit 2 additional correctable, bit 3 additional uncorrectable, bit 4 first error was uncorrectable, bits 11:8 phase code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pg_rst_n | input | 1 | Power-good reset, active low, asynchronous; clears all state |
| link_rst_n | input | 1 | Link reset, active low; clears only the read data |
| pri_err_vld | input | 1 | Primary interface error event |
| pri_err_uncorr | input | 1 | Primary event is uncorrectable |
| pri_err_phase | input | PHASE_W | Primary error phase code |
| pri_err_addr_lo | input | DATA_W | Primary error address, low word |
| pri_err_addr_hi | input | DATA_W | Primary error upper address or second data phase |
| pri_err_attr | input | DATA_W | Primary error attribute word |
| sec_err_vld | input | 1 | Secondary interface error event |
| sec_err_uncorr | input | 1 | Secondary event is uncorrectable |
| sec_err_phase | input | PHASE_W | Secondary error phase code |
| sec_err_addr_lo | input | DATA_W | Secondary error address, low word |
| sec_err_addr_hi | input | DATA_W | Secondary error upper address or second data phase |
| sec_err_attr | input | DATA_W | Secondary error attribute word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word offset in the window |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
Almost every piece of internal state is observable only through the read window. A wrongly captured field or a lost sticky flag therefore shows up only on the next read of that offset, exactly one clock after the read strobe. A capture that re-fires on a later error shows up as changed address words on the next read of offsets 1 to 3. The other-bank bit is the one place where the hidden secondary bank shows while the primary bank is selected. Reading offset 0 with select at 0 after each capture and clear exposes a phase field that fails to re-arm. The reference model predicts `reg_rdata` on every clock, so a read data register that drifts is caught at once.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {
    OFF_CSR   = 2'd0,
    OFF_ADDR1 = 2'd1,
    OFF_ADDR2 = 2'd2,
    OFF_ATTR  = 2'd3
  } reg_off_e;

  localparam int unsigned CSR_SEL       = 0;
  localparam int unsigned CSR_OTHER     = 1;
  localparam int unsigned CSR_MORE_CE   = 2;
  localparam int unsigned CSR_MORE_UE   = 3;
  localparam int unsigned CSR_FIRST_UE  = 4;
  localparam int unsigned CSR_PHASE_LSB = 8;

  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_PRI  = 0;
  localparam int unsigned BANK_SEC  = 1;
endpackage

// File: rtl/ecc_log_bank.sv
module ecc_log_bank #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PHASE_W = 4,
  parameter bit          ENABLE  = 1'b1
) (
  input  logic               clk,
  input  logic               pg_rst_n,
  input  logic               err_vld,
  input  logic               err_uncorr,
  input  logic [PHASE_W-1:0] err_phase,
  input  logic [DATA_W-1:0]  err_addr_lo,
  input  logic [DATA_W-1:0]  err_addr_hi,
  input  logic [DATA_W-1:0]  err_attr,
  input  logic               csr_we,
  input  logic               clr_ce,
  input  logic               clr_ue,
  input  logic               clr_phase,
  output logic [PHASE_W-1:0] phase_q,
  output logic [DATA_W-1:0]  addr1_q,
  output logic [DATA_W-1:0]  addr2_q,
  output logic [DATA_W-1:0]  attr_q,
  output logic               more_ce_q,
  output logic               more_ue_q,
  output logic               first_ue_q
);
  generate
    if (ENABLE) begin : g_live
      logic armed;
      logic cap_evt;
      logic more_evt;

      assign armed    = (phase_q == '0);
      assign cap_evt  = err_vld && armed && (err_phase != '0);
      assign more_evt = err_vld && !armed;

      always_ff @(posedge clk or negedge pg_rst_n) begin
        if (!pg_rst_n) begin
          phase_q    <= '0;
          addr1_q    <= '0;
          addr2_q    <= '0;
          attr_q     <= '0;
          first_ue_q <= 1'b0;
        end else if (cap_evt) begin
          phase_q    <= err_phase;
          addr1_q    <= err_addr_lo;
          addr2_q    <= err_addr_hi;
          attr_q     <= err_attr;
          first_ue_q <= err_uncorr;
        end else if (csr_we && clr_phase) begin
          phase_q <= '0;
        end
      end

      always_ff @(posedge clk or negedge pg_rst_n) begin
        if (!pg_rst_n) begin
          more_ce_q <= 1'b0;
          more_ue_q <= 1'b0;
        end else begin
          if (more_evt && !err_uncorr)   more_ce_q <= 1'b1;
          else if (csr_we && clr_ce)     more_ce_q <= 1'b0;
          if (more_evt && err_uncorr)    more_ue_q <= 1'b1;
          else if (csr_we && clr_ue)     more_ue_q <= 1'b0;
        end
      end

      p_capture_r2: assert property (@(posedge clk) disable iff (!pg_rst_n)
        cap_evt |=> (phase_q == $past(err_phase)) && (addr1_q == $past(err_addr_lo))
                    && (addr2_q == $past(err_addr_hi)) && (attr_q == $past(err_attr)));
      p_hold_r3: assert property (@(posedge clk) disable iff (!pg_rst_n)
        more_evt |=> $stable(addr1_q) && $stable(addr2_q) && $stable(attr_q) && $stable(first_ue_q));
      p_more_ue_r3: assert property (@(posedge clk) disable iff (!pg_rst_n)
        (more_evt && err_uncorr) |=> more_ue_q);
      p_more_ce_r3: assert property (@(posedge clk) disable iff (!pg_rst_n)
        (more_evt && !err_uncorr) |=> more_ce_q);
      p_sticky_ce_r4: assert property (@(posedge clk) disable iff (!pg_rst_n)
        (more_ce_q && !(csr_we && clr_ce)) |=> more_ce_q);
      p_sticky_ue_r4: assert property (@(posedge clk) disable iff (!pg_rst_n)
        (more_ue_q && !(csr_we && clr_ue)) |=> more_ue_q);
      p_rearm_r5: assert property (@(posedge clk) disable iff (!pg_rst_n)
        (csr_we && clr_phase && !armed) |=> (phase_q == '0) && $stable(addr1_q) && $stable(attr_q));
    end else begin : g_idle
      logic unused_inputs;
      assign unused_inputs = ^{clk, pg_rst_n, err_vld, err_uncorr, err_phase, err_addr_lo,
                               err_addr_hi, err_attr, csr_we, clr_ce, clr_ue, clr_phase};
      assign phase_q    = '0;
      assign addr1_q    = '0;
      assign addr2_q    = '0;
      assign attr_q     = '0;
      assign more_ce_q  = 1'b0;
      assign more_ue_q  = 1'b0;
      assign first_ue_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ecc_log_access.sv
module ecc_log_access
  import ecc_log_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PHASE_W = 4
) (
  input  logic                               clk,
  input  logic                               pg_rst_n,
  input  logic                               link_rst_n,
  input  logic                               reg_wr,
  input  logic                               reg_rd,
  input  logic [1:0]                         reg_addr,
  input  logic [DATA_W-1:0]                  reg_wdata,
  input  logic [NUM_BANKS-1:0][PHASE_W-1:0]  phase,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   addr1,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   addr2,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]   attr,
  input  logic [NUM_BANKS-1:0]               more_ce,
  input  logic [NUM_BANKS-1:0]               more_ue,
  input  logic [NUM_BANKS-1:0]               first_ue,
  output logic [NUM_BANKS-1:0]               csr_we,
  output logic                               clr_ce,
  output logic                               clr_ue,
  output logic                               clr_phase,
  output logic [DATA_W-1:0]                  reg_rdata
);
  localparam int unsigned PHASE_HI = CSR_PHASE_LSB + PHASE_W - 1;

  function automatic logic [DATA_W-1:0] pack_csr(input logic [PHASE_W-1:0] ph, input logic ce,
                                                 input logic ue, input logic fue,
                                                 input logic sel, input logic other);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CSR_SEL]                      = sel;
    w[CSR_OTHER]                    = other;
    w[CSR_MORE_CE]                  = ce;
    w[CSR_MORE_UE]                  = ue;
    w[CSR_FIRST_UE]                 = fue;
    w[PHASE_HI:CSR_PHASE_LSB]       = ph;
    return w;
  endfunction

  logic sel_q;
  logic csr_wr_hit;
  logic wr_bank;
  logic other_present;
  logic rd_rst_n;
  logic [DATA_W-1:0] rd_word;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign csr_wr_hit = reg_wr && (reg_addr == OFF_CSR);
  assign wr_bank    = reg_wdata[CSR_SEL];
  assign clr_ce     = reg_wdata[CSR_MORE_CE];
  assign clr_ue     = reg_wdata[CSR_MORE_UE];
  assign clr_phase  = (reg_wdata[PHASE_HI:CSR_PHASE_LSB] != '0);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
      assign csr_we[b] = csr_wr_hit && (wr_bank == 1'(b));
    end
  endgenerate

  always_ff @(posedge clk or negedge pg_rst_n) begin
    if (!pg_rst_n)       sel_q <= 1'b0;
    else if (csr_wr_hit) sel_q <= wr_bank;
  end

  assign other_present = (phase[~sel_q] != '0);

  always_comb begin
    unique case (reg_off_e'(reg_addr))
      OFF_CSR:   rd_word = pack_csr(phase[sel_q], more_ce[sel_q], more_ue[sel_q],
                                    first_ue[sel_q], sel_q, other_present);
      OFF_ADDR1: rd_word = addr1[sel_q];
      OFF_ADDR2: rd_word = addr2[sel_q];
      default:   rd_word = attr[sel_q];
    endcase
  end

  assign rd_rst_n = pg_rst_n & link_rst_n;

  always_ff @(posedge clk or negedge rd_rst_n) begin
    if (!rd_rst_n)   reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  p_pri_quiet_r9: assert property (@(posedge clk) disable iff (!pg_rst_n)
    (phase[BANK_PRI] == '0) && (addr1[BANK_PRI] == '0) && (addr2[BANK_PRI] == '0)
    && (attr[BANK_PRI] == '0) && !more_ce[BANK_PRI] && !more_ue[BANK_PRI]);
  p_sel_load_r7: assert property (@(posedge clk) disable iff (!pg_rst_n)
    csr_wr_hit |=> (sel_q == $past(reg_wdata[CSR_SEL])));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!pg_rst_n || !link_rst_n)
    !reg_rd |=> $stable(reg_rdata));
  p_other_r8: assert property (@(posedge clk) disable iff (!pg_rst_n || !link_rst_n)
    (reg_rd && (reg_addr == OFF_CSR) && !sel_q) |=>
      (reg_rdata[CSR_OTHER] == $past(phase[BANK_SEC] != '0)));
endmodule

// File: rtl/ecc_dual_log.sv
module ecc_dual_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk,
  input  logic               pg_rst_n,
  input  logic               link_rst_n,
  input  logic               pri_err_vld,
  input  logic               pri_err_uncorr,
  input  logic [PHASE_W-1:0] pri_err_phase,
  input  logic [DATA_W-1:0]  pri_err_addr_lo,
  input  logic [DATA_W-1:0]  pri_err_addr_hi,
  input  logic [DATA_W-1:0]  pri_err_attr,
  input  logic               sec_err_vld,
  input  logic               sec_err_uncorr,
  input  logic [PHASE_W-1:0] sec_err_phase,
  input  logic [DATA_W-1:0]  sec_err_addr_lo,
  input  logic [DATA_W-1:0]  sec_err_addr_hi,
  input  logic [DATA_W-1:0]  sec_err_attr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic [NUM_BANKS-1:0]              e_vld, e_unc;
  logic [NUM_BANKS-1:0][PHASE_W-1:0] e_ph;
  logic [NUM_BANKS-1:0][DATA_W-1:0]  e_lo, e_hi, e_at;

  logic [NUM_BANKS-1:0][PHASE_W-1:0] b_phase;
  logic [NUM_BANKS-1:0][DATA_W-1:0]  b_addr1, b_addr2, b_attr;
  logic [NUM_BANKS-1:0]              b_ce, b_ue, b_fue, b_we;
  logic                              w_clr_ce, w_clr_ue, w_clr_ph;

  assign e_vld = {sec_err_vld, pri_err_vld};
  assign e_unc = {sec_err_uncorr, pri_err_uncorr};
  assign e_ph  = {sec_err_phase, pri_err_phase};
  assign e_lo  = {sec_err_addr_lo, pri_err_addr_lo};
  assign e_hi  = {sec_err_addr_hi, pri_err_addr_hi};
  assign e_at  = {sec_err_attr, pri_err_attr};

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ecc_log_bank #(
        .DATA_W (DATA_W),
        .PHASE_W(PHASE_W),
        .ENABLE (b == BANK_SEC)
      ) bank_i (
        .clk        (clk),
        .pg_rst_n   (pg_rst_n),
        .err_vld    (e_vld[b]),
        .err_uncorr (e_unc[b]),
        .err_phase  (e_ph[b]),
        .err_addr_lo(e_lo[b]),
        .err_addr_hi(e_hi[b]),
        .err_attr   (e_at[b]),
        .csr_we     (b_we[b]),
        .clr_ce     (w_clr_ce),
        .clr_ue     (w_clr_ue),
        .clr_phase  (w_clr_ph),
        .phase_q    (b_phase[b]),
        .addr1_q    (b_addr1[b]),
        .addr2_q    (b_addr2[b]),
        .attr_q     (b_attr[b]),
        .more_ce_q  (b_ce[b]),
        .more_ue_q  (b_ue[b]),
        .first_ue_q (b_fue[b])
      );
    end
  endgenerate

  ecc_log_access #(
    .DATA_W (DATA_W),
    .PHASE_W(PHASE_W)
  ) access_i (
    .clk       (clk),
    .pg_rst_n  (pg_rst_n),
    .link_rst_n(link_rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .phase     (b_phase),
    .addr1     (b_addr1),
    .addr2     (b_addr2),
    .attr      (b_attr),
    .more_ce   (b_ce),
    .more_ue   (b_ue),
    .first_ue  (b_fue),
    .csr_we    (b_we),
    .clr_ce    (w_clr_ce),
    .clr_ue    (w_clr_ue),
    .clr_phase (w_clr_ph),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: tb/ecc_dual_log_tb_top.sv
`timescale 1ns/1ps
module ecc_dual_log_tb_top;
  logic        clk = 1'b0;
  logic        pg_rst_n = 1'b0, link_rst_n = 1'b1;
  logic        pri_err_vld = 0, pri_err_uncorr = 0;
  logic [3:0]  pri_err_phase = 0;
  logic [31:0] pri_err_addr_lo = 0, pri_err_addr_hi = 0, pri_err_attr = 0;
  logic        sec_err_vld = 0, sec_err_uncorr = 0;
  logic [3:0]  sec_err_phase = 0;
  logic [31:0] sec_err_addr_lo = 0, sec_err_addr_hi = 0, sec_err_attr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit          m_sel, m_ce, m_ue, m_fue;
  int          m_phase;
  logic [31:0] m_a1, m_a2, m_at, m_rd;

  always #4 clk = ~clk;

  ecc_dual_log dut_i (.*);

  function automatic logic [31:0] model_read(input logic [1:0] off);
    logic [31:0] w = 0;
    if (!m_sel) begin
      if (off == 0) begin w[0] = 0; w[1] = (m_phase != 0); end
    end else begin
      case (off)
        2'd0: begin
          w[0] = 1; w[1] = 0; w[2] = m_ce; w[3] = m_ue; w[4] = m_fue;
          w[11:8] = m_phase[3:0];
        end
        2'd1: w = m_a1;
        2'd2: w = m_a2;
        default: w = m_at;
      endcase
    end
    return w;
  endfunction

  task automatic tick(input string tag);
    bit n_sel = m_sel, n_ce = m_ce, n_ue = m_ue, n_fue = m_fue;
    int n_phase = m_phase;
    logic [31:0] n_a1 = m_a1, n_a2 = m_a2, n_at = m_at, exp_rd;
    exp_rd = reg_rd ? model_read(reg_addr) : m_rd;
    if (reg_wr && reg_addr == 0) begin
      n_sel = reg_wdata[0];
      if (reg_wdata[0]) begin
        if (reg_wdata[2]) n_ce = 0;
        if (reg_wdata[3]) n_ue = 0;
        if (reg_wdata[11:8] != 0 && m_phase != 0) n_phase = 0;
      end
    end
    if (sec_err_vld) begin
      if (m_phase == 0) begin
        if (sec_err_phase != 0) begin
          n_phase = sec_err_phase; n_a1 = sec_err_addr_lo; n_a2 = sec_err_addr_hi;
          n_at = sec_err_attr; n_fue = sec_err_uncorr;
        end
      end else if (sec_err_uncorr) n_ue = 1;
      else n_ce = 1;
    end
    if (!link_rst_n) exp_rd = 0;
    if (!pg_rst_n) begin
      n_sel = 0; n_ce = 0; n_ue = 0; n_fue = 0; n_phase = 0;
      n_a1 = 0; n_a2 = 0; n_at = 0; exp_rd = 0;
    end
    @(posedge clk); #1;
    m_sel = n_sel; m_ce = n_ce; m_ue = n_ue; m_fue = n_fue; m_phase = n_phase;
    m_a1 = n_a1; m_a2 = n_a2; m_at = n_at; m_rd = exp_rd;
    checks++;
    if (reg_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s: reg_rdata actual %h expected %h at %0t", tag, reg_rdata, exp_rd, $time);
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; sec_err_vld = 0; pri_err_vld = 0; link_rst_n = 1;
  endtask

  task automatic rd(input logic [1:0] off, input string tag);
    reg_rd = 1; reg_addr = off; tick(tag);
  endtask

  task automatic wr_csr(input logic [31:0] d, input string tag);
    reg_wr = 1; reg_addr = 0; reg_wdata = d; tick(tag);
  endtask

  task automatic sec_err(input bit unc, input logic [3:0] ph, input logic [31:0] lo, hi, at,
                         input string tag);
    sec_err_vld = 1; sec_err_uncorr = unc; sec_err_phase = ph;
    sec_err_addr_lo = lo; sec_err_addr_hi = hi; sec_err_attr = at; tick(tag);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 4; i++) rd(2'(i), tag);
  endtask

  initial begin
    m_sel = 0; m_ce = 0; m_ue = 0; m_fue = 0; m_phase = 0;
    m_a1 = 0; m_a2 = 0; m_at = 0; m_rd = 0;
    @(negedge clk);
    tick("R1"); tick("R1");
    pg_rst_n = 1; tick("R1");
    rd_all("R1");
    wr_csr(32'h1, "R6"); rd_all("R1");
    // primary events never land (R9)
    wr_csr(32'h0, "R9");
    pri_err_vld = 1; pri_err_phase = 4'h5; pri_err_addr_lo = 32'hAAAA0000; pri_err_attr = 32'h77;
    tick("R9");
    pri_err_vld = 1; pri_err_uncorr = 1; tick("R9");
    rd_all("R9");
    wr_csr(32'h1, "R9"); rd_all("R9");
    // zero phase code ignored (R2)
    sec_err(0, 4'h0, 32'h1111, 32'h2222, 32'h3333, "R2");
    rd_all("R2");
    // first capture (R2)
    sec_err(1, 4'h3, 32'hDEAD0010, 32'h00000001, 32'h0000C0DE, "R2");
    rd_all("R2");
    // later errors (R3)
    sec_err(0, 4'h6, 32'h5555, 32'h6666, 32'h7777, "R3");
    rd_all("R3");
    sec_err(1, 4'h2, 32'h8888, 32'h9999, 32'hAAAA, "R3");
    rd_all("R3");
    // other-bank bit with select at 0 (R8, R6)
    wr_csr(32'h0000_0F0C, "R7");
    rd_all("R8");
    wr_csr(32'h1, "R6"); rd(0, "R7");
    // writes to other offsets ignored (R7)
    reg_wr = 1; reg_addr = 1; reg_wdata = 32'hFFFF_FFFF; tick("R7");
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h0; tick("R7");
    rd_all("R7");
    // W1C (R4)
    wr_csr(32'h0000_0001, "R4"); rd(0, "R4");
    wr_csr(32'h0000_0005, "R4"); rd(0, "R4");
    sec_err(0, 4'h1, 0, 0, 0, "R4"); rd(0, "R4");
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0000_000D;
    sec_err(0, 4'h1, 0, 0, 0, "R4"); rd(0, "R4");
    wr_csr(32'h0000_000D, "R4"); rd(0, "R4");
    // link reset (R10)
    reg_rd = 1; reg_addr = 1; link_rst_n = 0; tick("R10");
    tick("R10");
    rd_all("R10");
    // read hold (R11)
    rd(2, "R11"); tick("R11"); tick("R11");
    sec_err(1, 4'h4, 1, 2, 3, "R11"); tick("R11");
    // phase clear re-arms, addresses retained (R5)
    wr_csr(32'h0000_0101, "R5");
    rd_all("R5");
    wr_csr(32'h0, "R5"); rd(0, "R8");
    wr_csr(32'h1, "R5");
    sec_err(0, 4'h9, 32'h0BAD_F00D, 32'h4, 32'h5, "R5");
    rd_all("R5");
    // second pg reset (R1)
    pg_rst_n = 0; tick("R1");
    pg_rst_n = 1; tick("R1");
    rd_all("R1");
    wr_csr(32'h1, "R1"); rd_all("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule